// File: doc/BRIEF.md
# Vertex Position Assembler

This block sits behind a geometry command decoder. It receives parameter words one at a time, and each word is tagged with the command code it belongs to. From these it rebuilds a full three-axis vertex position in signed 4.12 fixed point (16 bits, 12 of them fraction, range -8.0 up to just under +8.0). When the final parameter word of a position command has been taken, it reports the vertex with a one-cycle valid pulse.

The block keeps the most recently completed position as the last vertex. Commands that carry only two axes take the third axis from it. The relative command adds small deltas to it. A position-test command also uses the two-word layout, but it only overwrites the last vertex and sends nothing downstream. Reset sets the last vertex to the origin.

Top module: `vertex_pos_asm`

## Requirements
- R1: After reset, vtxValid is 0 and vtxX, vtxY and vtxZ are 0. The last vertex is (0,0,0), so a two-axis command issued right after reset inherits 0 for its missing axis.
- R2: Code 0x23 takes two words. The first word gives X in bits 15:0 and Y in bits 31:16. The second word gives Z in bits 15:0, and its bits 31:16 have no effect.
- R3: After the first word of a two-word command (0x23 or 0x71), vtxValid stays 0 and the last vertex does not change. The next word, whatever its tag, is consumed as the second word.
- R4: Code 0x24 holds three 10-bit signed fields: X in bits 9:0, Y in bits 19:10, Z in bits 29:20. Each field is shifted left by 6 to give 4.12 format, and bits 31:30 are ignored.
- R5: Code 0x25 sets X from bits 15:0 and Y from bits 31:16. Z is kept from the last vertex.
- R6: Code 0x26 sets X from bits 15:0 and Z from bits 31:16. Y is kept from the last vertex.
- R7: Code 0x27 sets Y from bits 15:0 and Z from bits 31:16. X is kept from the last vertex.
- R8: Code 0x28 holds three 10-bit signed deltas with 12 fraction bits: X in bits 9:0, Y in bits 19:10, Z in bits 29:20. Each delta is sign-extended and added to the matching axis of the last vertex. The sum wraps modulo 2^16.
- R9: Code 0x71 uses the same two-word layout as 0x23. It never raises vtxValid. Its coordinates become the last vertex.
- R10: A word whose tag is not one of 0x23-0x28 or 0x71, arriving while no second word is awaited, causes no pulse and leaves the last vertex unchanged.
- R11: vtxValid rises in the cycle after the clock edge that takes the final word, and lasts one cycle unless another final word follows. vtxX, vtxY and vtxZ change only together with a pulse and then hold. Every emitted vertex becomes the last vertex.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wordValid | input | 1 | A parameter word is presented this cycle |
| wordCmd | input | 8 | Command code that the word belongs to |
| wordData | input | 32 | Parameter word |
| vtxValid | output | 1 | One-cycle pulse: a new vertex is on the outputs |
| vtxX | output | 16 | Assembled X, signed 4.12 |
| vtxY | output | 16 | Assembled Y, signed 4.12 |
| vtxZ | output | 16 | Assembled Z, signed 4.12 |

## Verification
The assertions assume the upstream decoder never splits a two-word command. Once a first word of 0x23 or 0x71 has arrived, the next presented word is taken to be its partner, so the pulse and hold checks read the pending state through that rule. The directed stimulus always sends both words of a pair back to back with the same tag. Stray codes are sent only when no pair is open. Each word is held for exactly one cycle, so a pulse always lines up with a single accepted word.

// File: rtl/vpa_pkg.sv
package vpa_pkg;
  localparam int CMD_W = 8;

  localparam logic [CMD_W-1:0] OP_FULL = 8'h23;
  localparam logic [CMD_W-1:0] OP_PACK = 8'h24;
  localparam logic [CMD_W-1:0] OP_XY   = 8'h25;
  localparam logic [CMD_W-1:0] OP_XZ   = 8'h26;
  localparam logic [CMD_W-1:0] OP_YZ   = 8'h27;
  localparam logic [CMD_W-1:0] OP_REL  = 8'h28;
  localparam logic [CMD_W-1:0] OP_TEST = 8'h71;

  typedef enum logic [3:0] {
    K_NONE, K_HOLD, K_FULL, K_TEST, K_PACK, K_XY, K_XZ, K_YZ, K_REL
  } stepKind_t;

  typedef struct packed {
    logic      hold;    // capture first word of a pair
    logic      commit;  // update remembered vertex
    logic      emit;    // present vertex downstream
    stepKind_t kind;
  } ctrlStrobe_t;
endpackage

// File: rtl/vpa_ctrl.sv
module vpa_ctrl
  import vpa_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wordValid,
  input  logic [CMD_W-1:0] wordCmd,
  output ctrlStrobe_t      strobe
);
  logic      waitSecond;
  stepKind_t pendKind;
  stepKind_t curKind;
  logic      pairOpener;
  logic      knownCode;

  always_comb begin
    pairOpener = (wordCmd == OP_FULL) || (wordCmd == OP_TEST);
    knownCode  = pairOpener || (wordCmd == OP_PACK) || (wordCmd == OP_XY) ||
                 (wordCmd == OP_XZ) || (wordCmd == OP_YZ) || (wordCmd == OP_REL);
  end

  always_comb begin
    curKind = K_NONE;
    if (wordValid) begin
      if (waitSecond) begin
        curKind = pendKind;
      end else begin
        case (wordCmd)
          OP_FULL, OP_TEST: curKind = K_HOLD;
          OP_PACK:          curKind = K_PACK;
          OP_XY:            curKind = K_XY;
          OP_XZ:            curKind = K_XZ;
          OP_YZ:            curKind = K_YZ;
          OP_REL:           curKind = K_REL;
          default:          curKind = K_NONE;
        endcase
      end
    end
  end

  always_comb begin
    strobe.kind   = curKind;
    strobe.hold   = (curKind == K_HOLD);
    strobe.commit = (curKind != K_NONE) && (curKind != K_HOLD);
    strobe.emit   = strobe.commit && (curKind != K_TEST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitSecond <= 1'b0;
      pendKind   <= K_FULL;
    end else if (wordValid) begin
      if (waitSecond) begin
        waitSecond <= 1'b0;
      end else if (pairOpener) begin
        waitSecond <= 1'b1;
        pendKind   <= (wordCmd == OP_TEST) ? K_TEST : K_FULL;
      end
    end
  end

  // R3
  second_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && waitSecond) |=> !waitSecond);

  // R10
  stray_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && !waitSecond && !knownCode) |=> !waitSecond);
endmodule

// File: rtl/vpa_datapath.sv
module vpa_datapath
  import vpa_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int COORD_W   = 16,
  parameter int FRAC_W    = 12,
  parameter int PACK_W    = 10,
  parameter int PACK_FRAC = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [WORD_W-1:0]   wordData,
  output logic                vtxValid,
  output logic [COORD_W-1:0]  vtxX,
  output logic [COORD_W-1:0]  vtxY,
  output logic [COORD_W-1:0]  vtxZ
);
  localparam int AXES       = 3;
  localparam int PACK_SHIFT = FRAC_W - PACK_FRAC;
  localparam int EXT_W      = COORD_W - PACK_W;

  logic [WORD_W-1:0]               holdWord;
  logic [AXES-1:0][COORD_W-1:0]    lastPos;
  logic [AXES-1:0][COORD_W-1:0]    outPos;
  logic [AXES-1:0][COORD_W-1:0]    nextPos;
  logic [AXES-1:0][COORD_W-1:0]    packVal;
  logic [AXES-1:0][COORD_W-1:0]    relVal;
  logic [COORD_W-1:0]              wordLo, wordHi, holdLo, holdHi;

  assign wordLo = wordData[COORD_W-1:0];
  assign wordHi = wordData[2*COORD_W-1 -: COORD_W];
  assign holdLo = holdWord[COORD_W-1:0];
  assign holdHi = holdWord[2*COORD_W-1 -: COORD_W];

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    logic [PACK_W-1:0]  field;
    logic [COORD_W-1:0] widened;
    assign field      = wordData[a*PACK_W +: PACK_W];
    assign widened    = {{EXT_W{field[PACK_W-1]}}, field};
    assign packVal[a] = widened << PACK_SHIFT;
    assign relVal[a]  = lastPos[a] + widened;
  end

  always_comb begin
    nextPos = lastPos;
    case (strobe.kind)
      K_FULL, K_TEST: begin
        nextPos[0] = holdLo;
        nextPos[1] = holdHi;
        nextPos[2] = wordLo;
      end
      K_PACK: nextPos = packVal;
      K_XY: begin
        nextPos[0] = wordLo;
        nextPos[1] = wordHi;
      end
      K_XZ: begin
        nextPos[0] = wordLo;
        nextPos[2] = wordHi;
      end
      K_YZ: begin
        nextPos[1] = wordLo;
        nextPos[2] = wordHi;
      end
      K_REL:   nextPos = relVal;
      default: nextPos = lastPos;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdWord <= '0;
      lastPos  <= '0;
      outPos   <= '0;
      vtxValid <= 1'b0;
    end else begin
      vtxValid <= strobe.emit;
      if (strobe.hold)   holdWord <= wordData;
      if (strobe.commit) lastPos  <= nextPos;
      if (strobe.emit)   outPos   <= nextPos;
    end
  end

  assign vtxX = outPos[0];
  assign vtxY = outPos[1];
  assign vtxZ = outPos[2];

  // R3
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hold |=> (!vtxValid && $stable(lastPos)));

  // R9
  test_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.kind == K_TEST) |=> (!vtxValid && lastPos[0] == $past(holdLo)
                                 && lastPos[1] == $past(holdHi)));

  // R5
  xy_keeps_z_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.kind == K_XY) |=> $stable(lastPos[2]));

  // R10
  idle_keeps_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.kind == K_NONE) |=> (!vtxValid && $stable(lastPos)));
endmodule

// File: rtl/vertex_pos_asm.sv
module vertex_pos_asm
  import vpa_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int COORD_W   = 16,
  parameter int FRAC_W    = 12,
  parameter int PACK_W    = 10,
  parameter int PACK_FRAC = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wordValid,
  input  logic [CMD_W-1:0]   wordCmd,
  input  logic [WORD_W-1:0]  wordData,
  output logic               vtxValid,
  output logic [COORD_W-1:0] vtxX,
  output logic [COORD_W-1:0] vtxY,
  output logic [COORD_W-1:0] vtxZ
);
  ctrlStrobe_t strobe;

  vpa_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wordValid (wordValid),
    .wordCmd   (wordCmd),
    .strobe    (strobe)
  );

  vpa_datapath #(
    .WORD_W    (WORD_W),
    .COORD_W   (COORD_W),
    .FRAC_W    (FRAC_W),
    .PACK_W    (PACK_W),
    .PACK_FRAC (PACK_FRAC)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wordData (wordData),
    .vtxValid (vtxValid),
    .vtxX     (vtxX),
    .vtxY     (vtxY),
    .vtxZ     (vtxZ)
  );

  // R11
  pulse_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    vtxValid |-> $past(wordValid));

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !vtxValid |-> ($stable(vtxX) && $stable(vtxY) && $stable(vtxZ)));
endmodule

// File: tb/sim_vertex_pos_asm.sv
module sim_vertex_pos_asm;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wordValid = 1'b0;
  logic [7:0]  wordCmd = '0;
  logic [31:0] wordData = '0;
  logic        vtxValid;
  logic [15:0] vtxX, vtxY, vtxZ;

  int total = 0;
  int bad = 0;
  logic [15:0] lx = '0, ly = '0, lz = '0;

  always #5 clk = ~clk;

  vertex_pos_asm u0 (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordCmd(wordCmd),
    .wordData(wordData), .vtxValid(vtxValid), .vtxX(vtxX), .vtxY(vtxY), .vtxZ(vtxZ)
  );

  function automatic logic [15:0] ext10(input logic [9:0] f);
    return {{6{f[9]}}, f};
  endfunction

  task automatic sendWord(input logic [7:0] c, input logic [31:0] d);
    @(negedge clk);
    wordValid = 1'b1; wordCmd = c; wordData = d;
    @(negedge clk);
    wordValid = 1'b0; wordCmd = '0; wordData = '0;
  endtask

  task automatic checkVtx(input string tag, input logic [15:0] ex, ey, ez);
    total++;
    if (!(vtxValid && vtxX == ex && vtxY == ey && vtxZ == ez)) begin
      bad++;
      $display("FAIL %s: got v=%0b (%h,%h,%h) want v=1 (%h,%h,%h)",
               tag, vtxValid, vtxX, vtxY, vtxZ, ex, ey, ez);
    end
    lx = ex; ly = ey; lz = ez;
  endtask

  task automatic checkQuiet(input string tag);
    total++;
    if (vtxValid !== 1'b0) begin
      bad++;
      $display("FAIL %s: got vtxValid=%0b want 0", tag, vtxValid);
    end
  endtask

  task automatic tReset;
    total++;
    if (vtxValid !== 1'b0 || vtxX !== 16'h0 || vtxY !== 16'h0 || vtxZ !== 16'h0) begin
      bad++;
      $display("FAIL R1 reset: got v=%0b (%h,%h,%h) want v=0 (0,0,0)", vtxValid, vtxX, vtxY, vtxZ);
    end
    sendWord(8'h25, {16'h1234, 16'h0567});
    checkVtx("R1 inherit zero Z", 16'h0567, 16'h1234, 16'h0000);
  endtask

  task automatic tFull;
    sendWord(8'h23, {16'hF000, 16'h0ABC});
    checkQuiet("R3 first word quiet");
    sendWord(8'h23, {16'hDEAD, 16'h7FFF});
    checkVtx("R2 two-word full", 16'h0ABC, 16'hF000, 16'h7FFF);
  endtask

  task automatic tPack;
    sendWord(8'h24, {2'b11, 10'h200, 10'h1FF, 10'h3FF});
    checkVtx("R4 packed", 16'hFFC0, 16'h7FC0, 16'h8000);
  endtask

  task automatic tPartial;
    sendWord(8'h26, {16'h1111, 16'h2222});
    checkVtx("R6 XZ keeps Y", 16'h2222, ly, 16'h1111);
    sendWord(8'h27, {16'h3333, 16'h4444});
    checkVtx("R7 YZ keeps X", lx, 16'h4444, 16'h3333);
    sendWord(8'h25, {16'h5555, 16'h6666});
    checkVtx("R5 XY keeps Z", 16'h6666, 16'h5555, lz);
  endtask

  task automatic tRel;
    sendWord(8'h23, {16'h8000, 16'h7FFF});
    sendWord(8'h23, {16'h0000, 16'h0010});
    checkVtx("R8 setup", 16'h7FFF, 16'h8000, 16'h0010);
    sendWord(8'h28, {2'b00, 10'h1FF, 10'h3FF, 10'h001});
    checkVtx("R8 relative wrap", 16'h8000, 16'h7FFF, 16'h020F);
    sendWord(8'h28, {2'b00, 10'h200, 10'h000, 10'h3FE});
    checkVtx("R8 negative delta", 16'h8000 + ext10(10'h3FE), 16'h7FFF,
             16'h020F + ext10(10'h200));
  endtask

  task automatic tTest;
    sendWord(8'h71, {16'h0303, 16'h0202});
    checkQuiet("R9 test first word");
    sendWord(8'h71, {16'hFFFF, 16'h0404});
    checkQuiet("R9 test second word");
    sendWord(8'h28, 32'h0);
    checkVtx("R9 test replaces last", 16'h0202, 16'h0303, 16'h0404);
  endtask

  task automatic tIgnore;
    sendWord(8'h20, 32'hFFFF_FFFF);
    checkQuiet("R10 code 0x20");
    sendWord(8'h72, 32'h1234_5678);
    checkQuiet("R10 code 0x72");
    sendWord(8'h28, 32'h0);
    checkVtx("R10 last unchanged", lx, ly, lz);
  endtask

  task automatic tPulse;
    sendWord(8'h25, {16'h0A0A, 16'h0B0B});
    checkVtx("R11 pulse", 16'h0B0B, 16'h0A0A, lz);
    @(negedge clk);
    total++;
    if (vtxValid !== 1'b0 || vtxX !== lx || vtxY !== ly || vtxZ !== lz) begin
      bad++;
      $display("FAIL R11 hold: got v=%0b (%h,%h,%h) want v=0 (%h,%h,%h)",
               vtxValid, vtxX, vtxY, vtxZ, lx, ly, lz);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset;
    tFull;
    tPack;
    tPartial;
    tRel;
    tTest;
    tIgnore;
    tPulse;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout want completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule